// File: doc/BRIEF.md
# Key Blob Error Status and Interrupt Unit

This unit collects the outcome of key blob processing for an external-memory decryption engine. A key unwrap engine reports integrity failures as a one-cycle pulse per context, and a one-cycle pulse when processing finishes. The unit keeps a sticky error bit for each context and a summary error flag. It also keeps a processing-done flag, and it reflects the block enable and key blob enable controls. These values are packed into one status word. An interrupt request is raised whenever the summary flag is set and interrupts are enabled.

Software can clear the recorded errors with a clear strobe. A force strobe, meant for testing, raises the summary flag without recording any per-context detail. Bus decoding and the unwrap cryptography sit outside this unit. They drive its strobes and control bits directly.

Top module: `kb_err_status`

## Requirements
- R1: The status word has this layout. Bit 0 is the summary error flag. Bits [19:16] are the per-context error bits, with bit 16 for context 0 up to bit 19 for context 3. Bit 31 is the done flag, bit 30 mirrors key blob enable and bit 29 mirrors block enable. Every other bit reads 0.
- R2: A context error pulse takes effect one clock later. Its bits are ORed into the per-context field, the summary flag is set, and both stay set until a clear or a force.
- R3: A force strobe with no error pulse in the same cycle sets the summary flag and zeroes the per-context field one clock later.
- R4: A clear strobe with no error pulse and no force in the same cycle zeroes both the summary flag and the per-context field one clock later.
- R5: When an error pulse arrives in the same cycle as a clear or a force, the new error wins. One clock later the field equals exactly the pulsed bits and the summary flag is 1. When force and clear arrive together, the summary flag is 1.
- R6: The interrupt output equals the summary flag ANDed with the interrupt enable input, with no added delay from the enable.
- R7: A done pulse while key blob enable is 1 sets the done flag one clock later. A done pulse while key blob enable is 0 leaves the done flag at 0.
- R8: While key blob enable is 0, the done flag is 0 one clock later and stays 0.
- R9: Status bits 30 and 29 follow the key blob enable and block enable inputs combinationally, in the same cycle.
- R10: A synchronous active-low reset clears the summary flag, the per-context field and the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_en_i | input | 1 | Block enable control bit |
| kb_en_i | input | 1 | Key blob processing enable control bit |
| irq_en_i | input | 1 | Interrupt enable control bit |
| ctx_err_i | input | N_CTX | Per-context integrity error pulses from the unwrap engine |
| done_i | input | 1 | Processing-done pulse from the unwrap engine |
| force_err_i | input | 1 | Test strobe that forces the summary error flag |
| clr_err_i | input | 1 | Strobe that clears the recorded errors |
| status_o | output | 32 | Packed status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an error pulse that lands in the same cycle as a clear or a force, on top of an error pattern already recorded. Each context bit can be old, new, both or neither, and each combination has to be seen. The stimulus reaches this with a sweep. For every trial it first clears the unit and pulses a chosen prior pattern. It then applies every pulse vector with every combination of clear and force in a single cycle, and compares the whole status word with a value computed arithmetically. Separate sweeps cover the interrupt gating and the done flag's dependence on key blob enable.

// File: rtl/kbs_pkg.sv
// Package: shared status word geometry for the key blob status unit.
// Assumes a 32-bit status word and a context field that fits below bit 29.
package kbs_pkg;
    localparam int STAT_W    = 32;
    localparam int DONE_BIT  = 31;
    localparam int KBEN_BIT  = 30;
    localparam int BLKEN_BIT = 29;
    localparam int CTX_LSB   = 16;
    localparam int ERR_BIT   = 0;
endpackage

// File: rtl/kbs_err_track.sv
// Module: sticky per-context error bits plus the summary error flag.
// New pulses take priority over clear and force in the same cycle.
// Assumes pulses and strobes are synchronous single-cycle signals.
module kbs_err_track #(
    parameter int N_CTX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CTX-1:0] pulse_i,
    input  logic             force_i,
    input  logic             clr_i,
    output logic [N_CTX-1:0] ctx_o,
    output logic             sum_o
);
    logic wipe;
    logic any_pulse;
    logic sum_q;

    // Old detail is discarded on either clear or force.
    assign wipe      = clr_i | force_i;
    assign any_pulse = |pulse_i;

    genvar g;
    generate
        for (g = 0; g < N_CTX; g++) begin : g_ctx
            logic bit_q;
            // Sticky flag for one context; a new pulse overrides a wipe.
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= (bit_q & ~wipe) | pulse_i[g];
            end
            assign ctx_o[g] = bit_q;
        end
    endgenerate

    // Summary flag: set by any pulse or force, cleared by clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= 1'b0;
        else        sum_q <= any_pulse | force_i | (sum_q & ~clr_i);
    end
    assign sum_o = sum_q;

    // R2
    pulse_sets_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |=> sum_o);
    // R2
    pulse_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |=> ((ctx_o & $past(pulse_i)) == $past(pulse_i)));
    // R3
    force_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && !any_pulse) |=> (sum_o && ctx_o == '0));
    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !force_i && !any_pulse) |=> (!sum_o && ctx_o == '0));
    // R2
    detail_implies_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_o != '0) |-> sum_o);
endmodule

// File: rtl/kbs_done_track.sv
// Module: processing-done flag, only meaningful while key blob enable is set.
// Assumes done_i is a single-cycle pulse from the unwrap engine.
module kbs_done_track (
    input  logic clk,
    input  logic rst_n,
    input  logic kb_en_i,
    input  logic done_i,
    output logic done_o
);
    logic done_q;

    // Done flag: held at 0 while disabled, set by a done pulse while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (!kb_en_i) done_q <= 1'b0;
        else if (done_i)   done_q <= 1'b1;
    end
    assign done_o = done_q;

    // R8
    disabled_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kb_en_i |=> !done_o);
    // R7
    enabled_pulse_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_en_i && done_i) |=> done_o);
endmodule

// File: rtl/kbs_irq_gate.sv
// Module: interrupt request gating of the summary error flag.
// Combinational on purpose so a change of enable acts in the same cycle.
module kbs_irq_gate (
    input  logic err_i,
    input  logic en_i,
    output logic irq_o
);
    // Request only when an error is recorded and interrupts are enabled.
    always_comb irq_o = err_i & en_i;
endmodule

// File: rtl/kb_err_status.sv
// Module: top of the key blob error status unit.
// Combines error tracking, done tracking and IRQ gating into one status word.
// Assumes N_CTX + CTX_LSB stays below the block enable mirror bit.
module kb_err_status
    import kbs_pkg::*;
#(
    parameter int N_CTX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_en_i,
    input  logic              kb_en_i,
    input  logic              irq_en_i,
    input  logic [N_CTX-1:0]  ctx_err_i,
    input  logic              done_i,
    input  logic              force_err_i,
    input  logic              clr_err_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic [N_CTX-1:0] ctx_w;
    logic             sum_w;
    logic             done_w;

    kbs_err_track #(.N_CTX(N_CTX)) err_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (ctx_err_i),
        .force_i (force_err_i),
        .clr_i   (clr_err_i),
        .ctx_o   (ctx_w),
        .sum_o   (sum_w)
    );

    kbs_done_track done_trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .kb_en_i (kb_en_i),
        .done_i  (done_i),
        .done_o  (done_w)
    );

    kbs_irq_gate irq_i (
        .err_i (sum_w),
        .en_i  (irq_en_i),
        .irq_o (irq_o)
    );

    // Pack the status word; unassigned bits stay zero.
    always_comb begin
        status_o                     = '0;
        status_o[ERR_BIT]            = sum_w;
        status_o[CTX_LSB +: N_CTX]   = ctx_w;
        status_o[BLKEN_BIT]          = blk_en_i;
        status_o[KBEN_BIT]           = kb_en_i;
        status_o[DONE_BIT]           = done_w;
    end

    // R6
    irq_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o[ERR_BIT] && irq_en_i));
    // R6
    err_enabled_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ERR_BIT] && irq_en_i) |-> irq_o);
    // R5
    new_error_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_err_i || force_err_i) && ctx_err_i != '0)
        |=> (status_o[CTX_LSB +: N_CTX] == $past(ctx_err_i) && status_o[ERR_BIT]));
    // R10
    reset_empties_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o[ERR_BIT] == 1'b0 && status_o[DONE_BIT] == 1'b0
                    && status_o[CTX_LSB +: N_CTX] == '0));
endmodule

// File: tb/kb_err_status_tb.sv
module kb_err_status_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        blk_en, kb_en, irq_en, done, force_e, clr_e;
    logic [3:0]  ctx_err;
    logic [31:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kb_err_status #(.N_CTX(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .blk_en_i(blk_en), .kb_en_i(kb_en),
        .irq_en_i(irq_en), .ctx_err_i(ctx_err), .done_i(done),
        .force_err_i(force_e), .clr_err_i(clr_err_i_w), .status_o(status), .irq_o(irq)
    );
    logic clr_err_i_w;
    assign clr_err_i_w = clr_e;

    function automatic logic [31:0] word(logic dn, logic kb, logic blk,
                                         logic [3:0] cx, logic er);
        return ({31'd0, dn} << 31) | ({31'd0, kb} << 30) | ({31'd0, blk} << 29)
             | ({28'd0, cx} << 16) | {31'd0, er};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with the given strobes; inputs change and are sampled at negedges.
    task automatic cycle(input logic [3:0] p, input logic c, input logic f, input logic d);
        ctx_err = p; clr_e = c; force_e = f; done = d;
        @(negedge clk);
        ctx_err = '0; clr_e = 1'b0; force_e = 1'b0; done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; blk_en = 0; kb_en = 0; irq_en = 0; done = 0;
        force_e = 0; clr_e = 0; ctx_err = '0;
        @(negedge clk); @(negedge clk);
        // R10 R1: reset state
        chk("R10 reset", status, 32'h0);
        chk("R6 reset irq", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 R1: mirrors follow inputs in the same cycle
        for (int m = 0; m < 4; m++) begin
            blk_en = m[0]; kb_en = m[1];
            #1;
            chk("R9 mirror", status, word(1'b0, m[1], m[0], 4'd0, 1'b0));
        end
        blk_en = 0; kb_en = 0;
        @(negedge clk);

        // R2 R3 R4 R5: sweep prior pattern x pulse x clear x force
        for (int prev = 0; prev < 16; prev++) begin
            for (int p = 0; p < 16; p++) begin
                for (int cf = 0; cf < 4; cf++) begin
                    logic [3:0] base, ex_ctx;
                    logic       ex_err;
                    cycle(4'd0, 1'b1, 1'b0, 1'b0);
                    if (prev != 0) cycle(prev[3:0], 1'b0, 1'b0, 1'b0);
                    chk("R2 sticky prior", status,
                        word(1'b0, 1'b0, 1'b0, prev[3:0], prev != 0));
                    cycle(p[3:0], cf[0], cf[1], 1'b0);
                    base   = (cf != 0) ? 4'd0 : prev[3:0];
                    ex_ctx = base | p[3:0];
                    ex_err = (p != 0) || cf[1] || ((prev != 0) && !cf[0]);
                    if (p != 0 && cf != 0)
                        chk("R5 new error wins", status, word(0, 0, 0, ex_ctx, ex_err));
                    else if (cf[1])
                        chk("R3 force", status, word(0, 0, 0, ex_ctx, ex_err));
                    else if (cf[0])
                        chk("R4 clear", status, word(0, 0, 0, ex_ctx, ex_err));
                    else
                        chk("R2 accumulate", status, word(0, 0, 0, ex_ctx, ex_err));
                end
            end
        end

        // R6: interrupt gating over error state and enable
        for (int e = 0; e < 2; e++) begin
            cycle(4'd0, 1'b1, 1'b0, 1'b0);
            if (e == 1) cycle(4'd0, 1'b0, 1'b1, 1'b0);
            for (int ie = 0; ie < 2; ie++) begin
                irq_en = ie[0];
                #1;
                chk("R6 irq", {31'd0, irq}, {31'd0, e[0] & ie[0]});
            end
            irq_en = 0;
        end
        cycle(4'd0, 1'b1, 1'b0, 1'b0);

        // R7: done pulse ignored while disabled
        kb_en = 0;
        cycle(4'd0, 1'b0, 1'b0, 1'b1);
        chk("R7 done ignored", status, word(0, 0, 0, 4'd0, 0));
        // R7: done pulse while enabled
        kb_en = 1;
        @(negedge clk);
        chk("R7 no pulse yet", status, word(0, 1, 0, 4'd0, 0));
        cycle(4'd0, 1'b0, 1'b0, 1'b1);
        chk("R7 done set", status, word(1, 1, 0, 4'd0, 0));
        @(negedge clk);
        chk("R7 done holds", status, word(1, 1, 0, 4'd0, 0));
        // R8: drop enable clears done and it stays clear
        kb_en = 0;
        @(negedge clk);
        chk("R8 done cleared", status, word(0, 0, 0, 4'd0, 0));
        kb_en = 1;
        @(negedge clk);
        chk("R8 stays clear", status, word(0, 1, 0, 4'd0, 0));

        // R10: reset mid-run with recorded state
        cycle(4'hA, 1'b0, 1'b0, 1'b1);
        chk("R2 pre-reset", status, word(1, 1, 0, 4'hA, 1));
        rst_n = 0;
        @(negedge clk);
        chk("R10 reset clears", status, word(0, 1, 0, 4'd0, 0));
        rst_n = 1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule